// File: doc/BRIEF.md
# Host Request Line Generator

This block drives the request lines that tell an external host when it should move data through a 16-bit parallel host port. Two FIFO fill levels come in: the outgoing FIFO, which holds data for the host to read, and the incoming FIFO, which takes words that the host writes. From these levels the block builds either one shared request line or two separate lines, one for reads and one for writes. A request is a level signal. It stays asserted for as long as its FIFO condition holds. The read request drops only when the outgoing FIFO is empty, and the write request drops only when the incoming FIFO is full.

Each pin has its own setting for asserted polarity and for drive type. A pin can be driven actively at all times, or it can act as an open drain that only pulls to the asserted level. The block also produces the qualified data strobes, pop and push. In normal mode these are qualified by chip select and address. In host DMA mode the acknowledge input qualifies them instead. All configuration inputs are sampled on the clock. When any configuration input changes, every request is dropped for one cycle.

Top module: `hreq_gen`

## Requirements
- R1: In double mode (`cfg_double`=1), the read-request pin (`rreq_*`) is asserted exactly when `cfg_rx_en`=1 and `out_level` is not zero.
- R2: In double mode, the write-request pin (`treq_*`) is asserted exactly when `cfg_tx_en`=1 and `in_level` is not equal to DEPTH. It is deasserted when the incoming FIFO is full.
- R3: In single mode (`cfg_double`=0), the shared request appears on the `rreq_*` pin. It is asserted when either enabled condition of R1 or R2 holds, and it uses `cfg_rx_pol` and `cfg_rx_od`. In this mode `treq_o` and `treq_oe` are both 0.
- R4: A polarity bit of 1 makes the asserted level of its pin high. A polarity bit of 0 makes the asserted level low.
- R5: With the drive bit at 0 (active drive), the pin's output enable is always 1. The pin's data is the asserted level while the request is asserted, and the inverse of that level otherwise.
- R6: With the drive bit at 1 (open drain), the pin's data is always the asserted level. The output enable is 1 only while the request is asserted.
- R7: Pin outputs reflect the levels and configuration sampled at the previous clock edge, so the latency is one cycle.
- R8: At the clock edge that first samples a changed configuration, every request is deasserted. That deassertion uses the new polarity and drive settings.
- R9: When `cfg_dma`=0, `pop_out` and `push_in` equal `host_cs` AND (`host_addr`==DATA_ADDR) AND `host_rd` or `host_wr` respectively. Both are registered one cycle.
- R10: When `cfg_dma`=1, `host_ack` replaces the chip select and address qualifier in R9.
- R11: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_double | input | 1 | 1 = separate read and write request pins |
| cfg_dma | input | 1 | 1 = acknowledge qualifies data strobes |
| cfg_rx_en | input | 1 | Enable read-request condition |
| cfg_tx_en | input | 1 | Enable write-request condition |
| cfg_rx_pol | input | 1 | Asserted level of rreq pin |
| cfg_tx_pol | input | 1 | Asserted level of treq pin |
| cfg_rx_od | input | 1 | 1 = rreq pin open drain |
| cfg_tx_od | input | 1 | 1 = treq pin open drain |
| out_level | input | LW | Outgoing FIFO fill level |
| in_level | input | LW | Incoming FIFO fill level |
| host_cs | input | 1 | Host chip select, active high |
| host_addr | input | AW | Host register address |
| host_ack | input | 1 | Host DMA acknowledge |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| rreq_o | output | 1 | Read or shared request pin data |
| rreq_oe | output | 1 | Read or shared request pin enable |
| treq_o | output | 1 | Write request pin data |
| treq_oe | output | 1 | Write request pin enable |
| pop_out | output | 1 | Qualified read of outgoing FIFO |
| push_in | output | 1 | Qualified write into incoming FIFO |

## Verification
A wrong fill-level comparison or a wrong mode selection shows up on the request pin data or enable exactly one cycle after the levels are presented. No other state delays it. A stale configuration register would either miss the one-cycle drop after a configuration change, or produce a drop where none belongs. Either error is visible on the edge right after the change. A fault in strobe qualification appears on `pop_out` or `push_in` one cycle after the host inputs. The sweeps cover every combination of configuration bits and every combination of strobe inputs.

// File: rtl/hreq_pkg.sv
package hreq_pkg;
  typedef struct packed {
    logic dbl;
    logic dma;
    logic rx_en;
    logic tx_en;
    logic rx_pol;
    logic tx_pol;
    logic rx_od;
    logic tx_od;
  } hreq_cfg_t;

  typedef struct packed {
    logic o;
    logic oe;
  } hreq_pin_t;

  localparam int NUM_PINS = 2;
endpackage

// File: rtl/hreq_cond.sv
module hreq_cond #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          dbl,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          clr,
  input  logic [LW-1:0] out_level,
  input  logic [LW-1:0] in_level,
  output logic [1:0]    act
);
  logic rx_c;
  logic tx_c;

  // Level conditions: read side drops only on empty, write side only on full
  assign rx_c = rx_en && (out_level != '0);
  assign tx_c = tx_en && (in_level != LW'(DEPTH));

  always_comb begin
    act = 2'b00;
    if (!clr) begin
      act[0] = dbl ? rx_c : (rx_c || tx_c);
      act[1] = dbl && tx_c;
    end
  end
endmodule

// File: rtl/hreq_pin.sv
module hreq_pin
  import hreq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      used,
  input  logic      act,
  input  logic      pol,
  input  logic      od,
  output hreq_pin_t pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= '0;
    end else if (!used) begin
      pin <= '0;
    end else if (od) begin
      pin.o  <= pol;
      pin.oe <= act;
    end else begin
      pin.o  <= act ? pol : ~pol;
      pin.oe <= 1'b1;
    end
  end
endmodule

// File: rtl/hreq_strobe.sv
module hreq_strobe #(
  parameter int AW = 3,
  parameter int DATA_ADDR = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma,
  input  logic          host_cs,
  input  logic [AW-1:0] host_addr,
  input  logic          host_ack,
  input  logic          host_rd,
  input  logic          host_wr,
  output logic          pop_out,
  output logic          push_in
);
  logic qual;

  assign qual = dma ? host_ack : (host_cs && (host_addr == AW'(DATA_ADDR)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_out <= 1'b0;
      push_in <= 1'b0;
    end else begin
      pop_out <= qual && host_rd;
      push_in <= qual && host_wr;
    end
  end
endmodule

// File: rtl/hreq_gen.sv
module hreq_gen
  import hreq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 3,
  parameter int DATA_ADDR = 0,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_double,
  input  logic          cfg_dma,
  input  logic          cfg_rx_en,
  input  logic          cfg_tx_en,
  input  logic          cfg_rx_pol,
  input  logic          cfg_tx_pol,
  input  logic          cfg_rx_od,
  input  logic          cfg_tx_od,
  input  logic [LW-1:0] out_level,
  input  logic [LW-1:0] in_level,
  input  logic          host_cs,
  input  logic [AW-1:0] host_addr,
  input  logic          host_ack,
  input  logic          host_rd,
  input  logic          host_wr,
  output logic          rreq_o,
  output logic          rreq_oe,
  output logic          treq_o,
  output logic          treq_oe,
  output logic          pop_out,
  output logic          push_in
);
  hreq_cfg_t cfg_now;
  hreq_cfg_t cfg_q;
  logic      cfg_chg;
  logic [NUM_PINS-1:0] act_v;
  logic [NUM_PINS-1:0] used_v;
  logic [NUM_PINS-1:0] pol_v;
  logic [NUM_PINS-1:0] od_v;
  hreq_pin_t pins [NUM_PINS];

  assign cfg_now = '{dbl: cfg_double, dma: cfg_dma, rx_en: cfg_rx_en,
                     tx_en: cfg_tx_en, rx_pol: cfg_rx_pol, tx_pol: cfg_tx_pol,
                     rx_od: cfg_rx_od, tx_od: cfg_tx_od};

  // Configuration tracked even in reset so that every change is seen once
  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end
  assign cfg_chg = (cfg_now != cfg_q);

  hreq_cond #(.DEPTH(DEPTH)) u_cond (
    .dbl      (cfg_double),
    .rx_en    (cfg_rx_en),
    .tx_en    (cfg_tx_en),
    .clr      (cfg_chg),
    .out_level(out_level),
    .in_level (in_level),
    .act      (act_v)
  );

  assign used_v = {cfg_double, 1'b1};
  assign pol_v  = {cfg_tx_pol, cfg_rx_pol};
  assign od_v   = {cfg_tx_od, cfg_rx_od};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    hreq_pin u_pin (
      .clk (clk),
      .rst (rst),
      .used(used_v[g]),
      .act (act_v[g]),
      .pol (pol_v[g]),
      .od  (od_v[g]),
      .pin (pins[g])
    );
  end

  assign rreq_o  = pins[0].o;
  assign rreq_oe = pins[0].oe;
  assign treq_o  = pins[1].o;
  assign treq_oe = pins[1].oe;

  hreq_strobe #(.AW(AW), .DATA_ADDR(DATA_ADDR)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .dma      (cfg_dma),
    .host_cs  (host_cs),
    .host_addr(host_addr),
    .host_ack (host_ack),
    .host_rd  (host_rd),
    .host_wr  (host_wr),
    .pop_out  (pop_out),
    .push_in  (push_in)
  );
endmodule

// File: rtl/hreq_gen_chk.sv
module hreq_gen_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_double,
  input logic          cfg_dma,
  input logic          cfg_rx_pol,
  input logic          cfg_tx_pol,
  input logic          cfg_rx_od,
  input logic          cfg_tx_od,
  input logic [LW-1:0] out_level,
  input logic [LW-1:0] in_level,
  input logic          host_ack,
  input logic          rreq_o,
  input logic          rreq_oe,
  input logic          treq_o,
  input logic          treq_oe,
  input logic          pop_out,
  input logic          push_in
);
  a_r1_rx_empty: assert property (@(posedge clk) disable iff (rst)
    (cfg_double && out_level == '0) |=> !(rreq_oe && rreq_o == $past(cfg_rx_pol)));

  a_r2_tx_full: assert property (@(posedge clk) disable iff (rst)
    (cfg_double && in_level == LW'(DEPTH)) |=> !(treq_oe && treq_o == $past(cfg_tx_pol)));

  a_r3_single_idle: assert property (@(posedge clk) disable iff (rst)
    !cfg_double |=> (!treq_oe && !treq_o));

  a_r5_active_drive: assert property (@(posedge clk) disable iff (rst)
    !cfg_rx_od |=> rreq_oe);

  a_r6_open_drain: assert property (@(posedge clk) disable iff (rst)
    cfg_tx_od |=> (!treq_oe || treq_o == $past(cfg_tx_pol)));

  a_r8_mode_clear: assert property (@(posedge clk) disable iff (rst)
    (cfg_double != $past(cfg_double)) |=> !(rreq_oe && rreq_o == $past(cfg_rx_pol)));

  a_r10_dma_qual: assert property (@(posedge clk) disable iff (rst)
    (cfg_dma && !host_ack) |=> (!pop_out && !push_in));
endmodule

bind hreq_gen hreq_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_double(cfg_double),
  .cfg_dma   (cfg_dma),
  .cfg_rx_pol(cfg_rx_pol),
  .cfg_tx_pol(cfg_tx_pol),
  .cfg_rx_od (cfg_rx_od),
  .cfg_tx_od (cfg_tx_od),
  .out_level (out_level),
  .in_level  (in_level),
  .host_ack  (host_ack),
  .rreq_o    (rreq_o),
  .rreq_oe   (rreq_oe),
  .treq_o    (treq_o),
  .treq_oe   (treq_oe),
  .pop_out   (pop_out),
  .push_in   (push_in)
);

// File: tb/test_hreq_gen.sv
module test_hreq_gen;
  localparam int DEPTH = 8;
  localparam int LW = 4;
  localparam int AW = 2;
  localparam int DATA_ADDR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg = 8'hFF;
  logic [LW-1:0] out_level = '0;
  logic [LW-1:0] in_level = '0;
  logic host_cs = 1'b0, host_ack = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic rreq_o, rreq_oe, treq_o, treq_oe, pop_out, push_in;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  hreq_gen #(.DEPTH(DEPTH), .AW(AW), .DATA_ADDR(DATA_ADDR)) i_hreq_gen (
    .clk(clk), .rst(rst),
    .cfg_double(cfg[0]), .cfg_dma(cfg[1]), .cfg_rx_en(cfg[2]), .cfg_tx_en(cfg[3]),
    .cfg_rx_pol(cfg[4]), .cfg_tx_pol(cfg[5]), .cfg_rx_od(cfg[6]), .cfg_tx_od(cfg[7]),
    .out_level(out_level), .in_level(in_level),
    .host_cs(host_cs), .host_addr(host_addr), .host_ack(host_ack),
    .host_rd(host_rd), .host_wr(host_wr),
    .rreq_o(rreq_o), .rreq_oe(rreq_oe), .treq_o(treq_o), .treq_oe(treq_oe),
    .pop_out(pop_out), .push_in(push_in)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Returns {data, enable}
  function automatic logic [1:0] pin_exp(input logic used, input logic a,
                                         input logic pol, input logic od);
    if (!used) return 2'b00;
    if (od) return {pol, a};
    return {a ? pol : ~pol, 1'b1};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 rreq", {rreq_o, rreq_oe}, 2'b00);
    chk("R11 treq", {treq_o, treq_oe}, 2'b00);
    chk("R11 strobes", {pop_out, push_in}, 2'b00);
    rst = 1'b0;

    for (int c = 0; c < 256; c++) begin
      cfg = c[7:0];
      @(negedge clk);
      // R8: first edge with new config drops all requests
      chk($sformatf("R8 rreq cfg=%0d", c), {rreq_o, rreq_oe},
          pin_exp(1'b1, 1'b0, cfg[4], cfg[6]));
      chk($sformatf("R8 treq cfg=%0d", c), {treq_o, treq_oe},
          pin_exp(cfg[0], 1'b0, cfg[5], cfg[7]));
      for (int lv = 0; lv < 9; lv++) begin
        logic rxc, txc, ra, ta;
        case (lv / 3)
          0: out_level = 4'd0;
          1: out_level = 4'd1;
          default: out_level = 4'd8;
        endcase
        case (lv % 3)
          0: in_level = 4'd0;
          1: in_level = 4'd7;
          default: in_level = 4'd8;
        endcase
        rxc = cfg[2] && (out_level != 0);
        txc = cfg[3] && (in_level != DEPTH);
        ra = cfg[0] ? rxc : (rxc || txc);
        ta = cfg[0] && txc;
        @(negedge clk);
        // R7 one-cycle latency; R4 polarity; R5/R6 drive type
        chk($sformatf("%s %s R4 R7 cfg=%0d lv=%0d", cfg[0] ? "R1" : "R3",
                      cfg[6] ? "R6" : "R5", c, lv),
            {rreq_o, rreq_oe}, pin_exp(1'b1, ra, cfg[4], cfg[6]));
        chk($sformatf("%s %s R4 R7 cfg=%0d lv=%0d", cfg[0] ? "R2" : "R3",
                      cfg[7] ? "R6" : "R5", c, lv),
            {treq_o, treq_oe}, pin_exp(cfg[0], ta, cfg[5], cfg[7]));
      end
    end

    for (int s = 0; s < 128; s++) begin
      logic q;
      cfg[1] = s[0];
      host_cs = s[1];
      host_addr = s[3:2];
      host_ack = s[4];
      host_rd = s[5];
      host_wr = s[6];
      q = s[0] ? s[4] : (s[1] && (s[3:2] == DATA_ADDR));
      @(negedge clk);
      chk($sformatf("%s strobe s=%0d", s[0] ? "R10" : "R9", s),
          {pop_out, push_in}, {q && s[5], q && s[6]});
    end

    summary();
  end
endmodule